// File: doc/BRIEF.md
# Flash Status Register Protection Unit

This unit keeps the 8-bit status register of a serial flash and rules on every write-type command before the write engine sees it. The command decoder presents one request pulse per command, along with the target byte address, the new status byte and the level of the active-low write-protect pin. In the same cycle, the unit answers with an accept flag or a reject flag for that command. Once a command is accepted, the engine runs it and reports back through a busy level and a one-cycle done pulse.

The status byte used for readback comes straight from this unit. Its layout is as follows:

| Bit | Meaning |
|-----|---------|
| 7 | Status-lock bit |
| 6..4 | Always read 0 |
| 3..2 | Array-protect pair |
| 1 | Write-enable latch |
| 0 | Busy |

The non-volatile bits are plain flops with a reset value. Serial timing and array access belong to neighbouring blocks.

Top module: `flash_sr_guard`

## Requirements
- R1: After reset the status byte reads 00h.
- R2: The status byte layout is bit 7 status-lock, bits 6..4 zero, bits 3..2 array-protect pair, bit 1 write-enable latch, bit 0 busy. An accepted status write loads only bits 7, 3 and 2 from the new byte, and the written bits 1 and 0 have no effect.
- R3: Status write, page program, sector erase and chip erase are rejected while the write-enable latch is 0. A rejected command leaves the latch unchanged.
- R4: The write-enable latch behaves as follows:
  - An accepted write-enable command sets the latch.
  - An accepted write-disable command clears it.
  - An engine done pulse that ends an accepted status write, program or erase clears it.
- R5: While the status-lock bit is 1 and the write-protect pin is low, status writes are rejected. This holds whichever of the two conditions arose first.
- R6: Driving the write-protect pin high alone lets status writes be accepted again.
- R7: If either array-protect bit is 1, page program and sector erase are rejected for every address.
- R8: Chip erase is accepted only while both array-protect bits are 0.
- R9: Busy is set from an accepted status write, program or erase until the engine done pulse. It also reads 1 while the engine busy input is high. While busy is 1, every command is rejected, and the status byte keeps reading normally.
- R10: Page program and sector erase whose address is at or above MEM_BYTES are rejected.
- R11: A cycle with more than one request bit set rejects every request in it.
- R12: The request vector bits are:
  - bit 0 write enable
  - bit 1 write disable
  - bit 2 status write
  - bit 3 page program
  - bit 4 sector erase
  - bit 5 chip erase

  Accept and reject flags use the same positions, appear in the request cycle, and the reject flags equal the requests not accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_req | input | 6 | One-cycle command request pulses |
| cmd_addr | input | ADDR_W | Target byte address for program and erase |
| sr_wdata | input | 8 | New status byte for a status write |
| wp_n | input | 1 | Write-protect pin level, low protects |
| eng_busy | input | 1 | Write engine reports an operation running |
| eng_done | input | 1 | Write engine completion pulse |
| cmd_ok | output | 6 | Accept flag per command |
| cmd_nak | output | 6 | Reject flag per command |
| sr_rdata | output | 8 | Status byte for readback |

## Verification
Directed sequences reach the lock state in both orders: the pin is lowered after the lock bit is set, and the lock bit is set while the pin is already low. Two further directed cases tell the write-enable gate apart from the lock gate:
- a status write with the latch clear;
- a status write with the latch set and the lock active.

The protect pair is stepped through its non-zero codes against program, sector erase and chip erase, and addresses just below and at the array size probe the range rule. Random traffic then mixes single requests, double requests, idle cycles, pin toggles, engine busy and done pulses, so that latch clearing on completion is tried against commands arriving while busy.

// File: rtl/flash_sr_guard.sv
module flash_sr_guard #(
  parameter int ADDR_W    = 24,
  parameter int MEM_BYTES = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        cmd_req,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        sr_wdata,
  input  logic              wp_n,
  input  logic              eng_busy,
  input  logic              eng_done,
  output logic [5:0]        cmd_ok,
  output logic [5:0]        cmd_nak,
  output logic [7:0]        sr_rdata
);
  localparam int C_WEN = 0, C_WDIS = 1, C_WSR = 2, C_PROG = 3, C_SERA = 4, C_CERA = 5;
  localparam logic [ADDR_W:0] ADDR_LIMIT = (ADDR_W+1)'(MEM_BYTES);

  logic       lock_bit, wel, active;
  logic [1:0] prot;

  logic busy, go, hw_lock, arr_open, addr_in;
  logic unused_wbits;

  assign busy         = active | eng_busy;
  assign go           = $onehot(cmd_req) & ~busy;
  assign hw_lock      = lock_bit & ~wp_n;
  assign arr_open     = (prot == 2'b00);
  assign addr_in      = {1'b0, cmd_addr} < ADDR_LIMIT;
  assign unused_wbits = ^{sr_wdata[6:4], sr_wdata[1:0]};

  assign cmd_ok[C_WEN]  = go & cmd_req[C_WEN];
  assign cmd_ok[C_WDIS] = go & cmd_req[C_WDIS];
  assign cmd_ok[C_WSR]  = go & cmd_req[C_WSR]  & wel & ~hw_lock;
  assign cmd_ok[C_PROG] = go & cmd_req[C_PROG] & wel & arr_open & addr_in;
  assign cmd_ok[C_SERA] = go & cmd_req[C_SERA] & wel & arr_open & addr_in;
  assign cmd_ok[C_CERA] = go & cmd_req[C_CERA] & wel & arr_open;
  assign cmd_nak        = cmd_req & ~cmd_ok;

  assign sr_rdata = {lock_bit, 3'b000, prot, wel, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_bit <= 1'b0;
      prot     <= 2'b00;
      wel      <= 1'b0;
      active   <= 1'b0;
    end else begin
      if (eng_done && active) begin
        active <= 1'b0;
        wel    <= 1'b0;
      end
      if (cmd_ok[C_WEN])  wel <= 1'b1;
      if (cmd_ok[C_WDIS]) wel <= 1'b0;
      if (cmd_ok[C_WSR]) begin
        lock_bit <= sr_wdata[7];
        prot     <= sr_wdata[3:2];
      end
      if (|cmd_ok[5:2]) active <= 1'b1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) $rose(rst_n) |-> (sr_rdata[7:1] == 7'd0));
  p_zero_bits_r2: assert property (@(posedge clk) disable iff (!rst_n) sr_rdata[6:4] == 3'b000);
  p_nonwrite_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ok[C_WSR] |=> $stable({sr_rdata[7], sr_rdata[3:2]}));
  p_need_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_ok[5:2]) |-> sr_rdata[1]);
  p_reject_keeps_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cmd_nak) && !(eng_done && active)) |=> $stable(wel));
  p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && active) |=> !sr_rdata[1]);
  p_hw_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rdata[7] && !wp_n) |-> !cmd_ok[C_WSR]);
  p_array_prot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rdata[3:2] != 2'b00) |-> !(cmd_ok[C_PROG] || cmd_ok[C_SERA] || cmd_ok[C_CERA]));
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sr_rdata[0] |-> (cmd_ok == 6'd0));
  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_ok[5:2]) |=> sr_rdata[0]);
  p_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cmd_req) > 1) |-> (cmd_ok == 6'd0));
  p_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_ok & cmd_nak) == 6'd0) && ((cmd_ok | cmd_nak) == cmd_req));
endmodule

// File: tb/flash_sr_guard_tb_top.sv
`timescale 1ns/1ps
module flash_sr_guard_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0]  cmd_req = '0;
  logic [23:0] cmd_addr = '0;
  logic [7:0]  sr_wdata = '0;
  logic wp_n = 1'b1, eng_busy = 1'b0, eng_done = 1'b0;
  logic [5:0] cmd_ok, cmd_nak;
  logic [7:0] sr_rdata;

  int vectors = 0, fails = 0;
  logic m_lock = 0, m_wel = 0, m_act = 0;
  logic [1:0] m_prot = 0;

  always #2.5 clk = ~clk;

  flash_sr_guard #(.ADDR_W(24), .MEM_BYTES(65536)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_addr(cmd_addr),
    .sr_wdata(sr_wdata), .wp_n(wp_n), .eng_busy(eng_busy), .eng_done(eng_done),
    .cmd_ok(cmd_ok), .cmd_nak(cmd_nak), .sr_rdata(sr_rdata));

  localparam logic [5:0] WEN = 6'd1, WDIS = 6'd2, WSR = 6'd4, PROG = 6'd8, SERA = 6'd16, CERA = 6'd32;

  function automatic logic [5:0] exp_ok(logic [5:0] rq, logic [23:0] ad, logic wp, logic eb);
    logic [5:0] r;
    logic inr;
    r = '0;
    if ($countones(rq) != 1 || m_act || eb) return r;
    inr = ad < 24'd65536;
    r[0] = rq[0];
    r[1] = rq[1];
    r[2] = rq[2] & m_wel & ~(m_lock & ~wp);
    r[3] = rq[3] & m_wel & (m_prot == 2'b00) & inr;
    r[4] = rq[4] & m_wel & (m_prot == 2'b00) & inr;
    r[5] = rq[5] & m_wel & (m_prot == 2'b00);
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [5:0] rq, input logic [23:0] ad, input logic [7:0] wd,
                      input logic wp, input logic eb, input logic dn, input string tag);
    logic [5:0] eo;
    @(negedge clk);
    cmd_req = rq; cmd_addr = ad; sr_wdata = wd; wp_n = wp; eng_busy = eb; eng_done = dn;
    #1;
    eo = exp_ok(rq, ad, wp, eb);
    check({tag, " R12 accept"}, {2'b00, cmd_ok}, {2'b00, eo});
    check({tag, " R12 reject"}, {2'b00, cmd_nak}, {2'b00, rq & ~eo});
    check({tag, " R2 status"}, sr_rdata, {m_lock, 3'b000, m_prot, m_wel, m_act | eb});
    if (dn && m_act) begin m_act = 0; m_wel = 0; end
    if (eo[0]) m_wel = 1;
    if (eo[1]) m_wel = 0;
    if (eo[2]) begin m_lock = wd[7]; m_prot = wd[3:2]; end
    if (|eo[5:2]) m_act = 1;
  endtask

  task automatic cmd(input logic [5:0] rq, input logic [7:0] wd, input logic wp, input string tag);
    step(rq, 24'h0, wd, wp, 1'b0, 1'b0, tag);
  endtask

  task automatic done();
    step(6'd0, 24'h0, 8'h0, 1'b1, 1'b0, 1'b1, "R4 done");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 check("R1 reset status", sr_rdata, 8'h00);
    rst_n = 1'b1;
    cmd(0, 0, 1, "R1 idle");
    cmd(WSR, 8'hFF, 1, "R3 wsr without latch");
    cmd(PROG, 0, 1, "R3 prog without latch");
    cmd(WEN, 0, 1, "R4 set latch");
    cmd(WSR, 8'h73, 1, "R2 masked write");
    cmd(0, 0, 1, "R9 busy readable");
    done();
    cmd(WEN, 0, 1, "R4 set");
    cmd(WDIS, 0, 1, "R4 clear");
    cmd(CERA, 0, 1, "R3 cerase without latch");
    cmd(WEN, 0, 1, "R4 set");
    cmd(WSR, 8'h80, 1, "R5 set lock pin high");
    done();
    cmd(WEN, 0, 0, "R5 wen pin low");
    cmd(WSR, 8'h00, 0, "R5 locked lock first");
    cmd(0, 0, 0, "R3 latch kept after reject");
    cmd(WSR, 8'h04, 1, "R6 pin high unlocks");
    done();
    cmd(WEN, 0, 0, "R5 wen");
    cmd(WSR, 8'h84, 0, "R5 set lock while pin low");
    done();
    cmd(WEN, 0, 0, "R5 wen");
    cmd(WSR, 8'h00, 0, "R5 locked pin first");
    cmd(WSR, 8'h04, 1, "R6 unlock");
    done();
    cmd(WEN, 0, 1, "R7 wen");
    cmd(PROG, 0, 1, "R7 prog protected");
    cmd(SERA, 0, 1, "R7 erase protected");
    cmd(CERA, 0, 1, "R8 cerase protected");
    cmd(WSR, 8'h08, 1, "R7 prot 10");
    done();
    cmd(WEN, 0, 1, "R8 wen");
    cmd(CERA, 0, 1, "R8 cerase prot 10");
    cmd(WSR, 8'h00, 1, "R8 clear prot");
    done();
    cmd(WEN, 0, 1, "R8 wen");
    cmd(CERA, 0, 1, "R8 cerase open");
    cmd(WEN, 0, 1, "R9 wen while busy");
    done();
    step(WEN, 0, 0, 1, 1, 0, "R9 engine busy");
    cmd(WEN, 0, 1, "R10 wen");
    step(PROG, 24'h010000, 0, 1, 0, 0, "R10 prog at limit");
    step(SERA, 24'hFFFFFF, 0, 1, 0, 0, "R10 erase far");
    step(PROG, 24'h00FFFF, 0, 1, 0, 0, "R10 prog last byte");
    done();
    cmd(WEN | WDIS, 0, 1, "R11 double wen wdis");
    cmd(WEN, 0, 1, "R11 wen");
    cmd(WSR | PROG, 0, 1, "R11 double write");
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] rq;
      logic [23:0] ad;
      int r;
      r = int'($urandom % 10);
      if (r == 0) rq = 0;
      else if (r == 1) rq = (6'd1 << ($urandom % 6)) | (6'd1 << ($urandom % 6));
      else if (r <= 3) rq = WEN;
      else rq = 6'd1 << ($urandom % 6);
      ad = ($urandom % 2) ? 24'($urandom % 65536) : 24'($urandom);
      step(rq, ad, 8'($urandom), ($urandom % 4) != 0, ($urandom % 16) == 0,
           m_act && (($urandom % 4) == 0), "R12 random");
    end
    step(0, 0, 0, 1, 0, 1, "R4 drain");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule